// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Generator

This block is the master end of an open-drain single-wire bus. It turns one accepted request into one bit-level time slot. A slot is a write-one, a write-zero or a read. Every slot starts with the master pulling the line low. The length of that low pulse is what carries a written bit: a short pulse writes a one, and a pulse lasting most of the slot writes a zero. A read slot uses the short pulse, then lets the line float so the slave can hold it low, and samples the line before the slave's earliest sampling point. Each slot is followed by a recovery gap with the line released. All lengths come from one of two timing tables, regular or overdrive, picked by a speed input when the request is accepted.

The controller is a four-state machine. IDLE waits for a request and is the only state in which ready is high. IDLE goes to LOW_PULSE when a request is accepted. LOW_PULSE drives the pull-low output. It goes to RELEASED when the low width has elapsed. It goes straight to RECOVER if the whole slot has elapsed first. RELEASED leaves the line free and goes to RECOVER when the slot length has elapsed. RECOVER keeps the line free for the recovery time and then returns to IDLE. On that return the done strobe fires with the bit result. The line is sampled once per slot, at a fixed count from the falling edge.

With the default 10 MHz clock (100 ns per cycle) the regular table is: 6 µs short low, 64 µs long low, 70 µs slot, 5 µs recovery, 13 µs sample point. The overdrive table is: 1 µs, 7.5 µs, 10 µs, 2.5 µs and 1.5 µs.

Top module: `sws_slot_master`

## Requirements
- R1: After reset, ready is 1, pull_low is 0, done is 0 and rd_bit is 0.
- R2: A write slot with wr_bit=1 (slot_rd=0) drives pull_low for exactly 60 cycles at regular speed (speed_od=0) and 10 cycles at overdrive (speed_od=1).
- R3: A write slot with wr_bit=0 (slot_rd=0) drives pull_low for exactly 640 cycles at regular speed and 75 cycles at overdrive. A low pulse is never longer than 640 cycles.
- R4: A read slot (slot_rd=1) drives pull_low for the write-one width and returns in rd_bit the level of line_in sampled 130 cycles (regular) or 15 cycles (overdrive) after the edge that accepted the request, so a slave holding the line low reads as 0.
- R5: done rises exactly 750 cycles (regular) or 125 cycles (overdrive) after the edge that accepted the request, covering slot plus recovery. Ready is 0 and pull_low is asserted in the cycle after acceptance. Ready stays 0 until done.
- R6: For write slots rd_bit carries the sampled line level: 0 for a write-zero, and for a write-one 1 on a free line or 0 when a slave holds the line low.
- R7: A request raised while ready is 0 is ignored and starts no slot.
- R8: slot_rd, wr_bit and speed_od are captured at acceptance. Changing them during a slot does not alter that slot's widths or result.
- R9: done is a single-cycle pulse, ready is 1 in that cycle, and pull_low is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Slot request, accepted when ready is 1 |
| slot_rd | input | 1 | 1 = read slot, 0 = write slot |
| wr_bit | input | 1 | Bit to write for a write slot |
| speed_od | input | 1 | 0 = regular timing, 1 = overdrive timing |
| ready | output | 1 | High only while idle |
| pull_low | output | 1 | Drives the open-drain line low when 1 |
| line_in | input | 1 | Synchronized level of the bus line |
| done | output | 1 | One-cycle strobe at end of recovery |
| rd_bit | output | 1 | Line level sampled during the last slot |

## Verification
Every result falls due at a fixed count from the accepting edge. pull_low appears one cycle after acceptance and lasts the exact low width. The line is sampled 130 or 15 cycles in. done and rd_bit arrive 750 or 125 cycles after acceptance. The monitor samples on the falling clock edge. It counts the cycles of the low pulse, then counts again from the first low cycle to the cycle done is seen, and compares both counts and rd_bit against the entry the driver queued at acceptance. Requests and parameter changes injected while ready is low are checked through the same counts. A slot arriving with no queued entry is reported against R7.

// File: rtl/sws_pkg.sv
package sws_pkg;

    // Controller states of the slot generator
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOW_PULSE = 2'd1,
        ST_RELEASED  = 2'd2,
        ST_RECOVER   = 2'd3
    } sws_state_e;

    // Request fields captured at acceptance
    typedef struct packed {
        logic rd;
        logic wbit;
        logic od;
    } sws_req_t;

    // Converts a duration in tenths of a microsecond to clock cycles, rounding up
    function automatic int unsigned tenths_to_cycles(input int unsigned tenths,
                                                     input int unsigned clk_mhz);
        return (tenths * clk_mhz + 9) / 10;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sws_speed_table.sv
module sws_speed_table
    import sws_pkg::*;
#(
    parameter int unsigned CW          = 10,
    parameter int unsigned REG_LOW1_C  = 60,
    parameter int unsigned REG_LOW0_C  = 640,
    parameter int unsigned REG_SLOT_C  = 700,
    parameter int unsigned REG_REC_C   = 50,
    parameter int unsigned REG_SMP_C   = 130,
    parameter int unsigned OD_LOW1_C   = 10,
    parameter int unsigned OD_LOW0_C   = 75,
    parameter int unsigned OD_SLOT_C   = 100,
    parameter int unsigned OD_REC_C    = 25,
    parameter int unsigned OD_SMP_C    = 15
) (
    input  sws_req_t        cur,
    output logic [CW-1:0]   low_len,
    output logic [CW-1:0]   slot_len,
    output logic [CW-1:0]   rec_len,
    output logic [CW-1:0]   smp_pt
);

    // The two timing tables, indexed by the captured speed bit
    logic [CW-1:0] tab_low1 [2];
    logic [CW-1:0] tab_low0 [2];
    logic [CW-1:0] tab_slot [2];
    logic [CW-1:0] tab_rec  [2];
    logic [CW-1:0] tab_smp  [2];

    assign tab_low1[0] = CW'(REG_LOW1_C);
    assign tab_low0[0] = CW'(REG_LOW0_C);
    assign tab_slot[0] = CW'(REG_SLOT_C);
    assign tab_rec[0]  = CW'(REG_REC_C);
    assign tab_smp[0]  = CW'(REG_SMP_C);
    assign tab_low1[1] = CW'(OD_LOW1_C);
    assign tab_low0[1] = CW'(OD_LOW0_C);
    assign tab_slot[1] = CW'(OD_SLOT_C);
    assign tab_rec[1]  = CW'(OD_REC_C);
    assign tab_smp[1]  = CW'(OD_SMP_C);

    logic short_low;

    always_comb begin
        // Reads and write-ones use the short pulse; only a written zero holds long
        short_low = cur.rd | cur.wbit;
        low_len   = short_low ? tab_low1[cur.od] : tab_low0[cur.od];
        slot_len  = tab_slot[cur.od];
        rec_len   = tab_rec[cur.od];
        smp_pt    = tab_smp[cur.od];
    end

endmodule

// File: rtl/sws_slot_fsm.sv
module sws_slot_fsm
    import sws_pkg::*;
#(
    parameter int unsigned CW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  sws_req_t        req_info,
    input  logic            line_in,
    input  logic [CW-1:0]   low_len,
    input  logic [CW-1:0]   slot_len,
    input  logic [CW-1:0]   rec_len,
    input  logic [CW-1:0]   smp_pt,
    output sws_req_t        cur,
    output logic            ready,
    output logic            pull_low,
    output logic            done,
    output logic            rd_bit
);

    sws_state_e    state, state_n;
    logic [CW-1:0] cnt;
    logic          smp_val;
    logic          at_low_end, at_slot_end, at_rec_end, in_slot, accept;

    always_comb begin
        at_low_end  = (cnt == low_len  - CW'(1));
        at_slot_end = (cnt == slot_len - CW'(1));
        at_rec_end  = (cnt == rec_len  - CW'(1));
        in_slot     = (state == ST_LOW_PULSE) || (state == ST_RELEASED);
        accept      = (state == ST_IDLE) && req;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (req) state_n = ST_LOW_PULSE;
            end
            ST_LOW_PULSE: begin
                if (at_slot_end)     state_n = ST_RECOVER;
                else if (at_low_end) state_n = ST_RELEASED;
            end
            ST_RELEASED: begin
                if (at_slot_end) state_n = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (at_rec_end) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register, slot counter and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cur   <= '0;
        end else begin
            state <= state_n;
            if (accept) begin
                cur <= req_info;
            end
            if (state_n == ST_IDLE) begin
                cnt <= '0;
            end else if ((state_n != state) &&
                         ((state_n == ST_LOW_PULSE) || (state_n == ST_RECOVER))) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // Registered outputs: line sample, result and completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_val <= 1'b0;
            rd_bit  <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= (state == ST_RECOVER) && at_rec_end;
            if (in_slot && (cnt == smp_pt)) begin
                smp_val <= line_in;
            end
            if ((state == ST_RECOVER) && at_rec_end) begin
                rd_bit <= smp_val;
            end
        end
    end

    assign ready    = (state == ST_IDLE);
    assign pull_low = (state == ST_LOW_PULSE);

endmodule

// File: rtl/sws_slot_master.sv
module sws_slot_master
    import sws_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 10,
    // Durations in tenths of a microsecond, regular speed
    parameter int unsigned REG_LOW1_T  = 60,
    parameter int unsigned REG_LOW0_T  = 640,
    parameter int unsigned REG_SLOT_T  = 700,
    parameter int unsigned REG_REC_T   = 50,
    parameter int unsigned REG_SMP_T   = 130,
    // Durations in tenths of a microsecond, overdrive speed
    parameter int unsigned OD_LOW1_T   = 10,
    parameter int unsigned OD_LOW0_T   = 75,
    parameter int unsigned OD_SLOT_T   = 100,
    parameter int unsigned OD_REC_T    = 25,
    parameter int unsigned OD_SMP_T    = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic slot_rd,
    input  logic wr_bit,
    input  logic speed_od,
    output logic ready,
    output logic pull_low,
    input  logic line_in,
    output logic done,
    output logic rd_bit
);

    localparam int unsigned REG_LOW1_C = tenths_to_cycles(REG_LOW1_T, CLK_MHZ);
    localparam int unsigned REG_LOW0_C = tenths_to_cycles(REG_LOW0_T, CLK_MHZ);
    localparam int unsigned REG_SLOT_C = tenths_to_cycles(REG_SLOT_T, CLK_MHZ);
    localparam int unsigned REG_REC_C  = tenths_to_cycles(REG_REC_T,  CLK_MHZ);
    localparam int unsigned REG_SMP_C  = tenths_to_cycles(REG_SMP_T,  CLK_MHZ);
    localparam int unsigned OD_LOW1_C  = tenths_to_cycles(OD_LOW1_T,  CLK_MHZ);
    localparam int unsigned OD_LOW0_C  = tenths_to_cycles(OD_LOW0_T,  CLK_MHZ);
    localparam int unsigned OD_SLOT_C  = tenths_to_cycles(OD_SLOT_T,  CLK_MHZ);
    localparam int unsigned OD_REC_C   = tenths_to_cycles(OD_REC_T,   CLK_MHZ);
    localparam int unsigned OD_SMP_C   = tenths_to_cycles(OD_SMP_T,   CLK_MHZ);
    localparam int unsigned MAX_C      = max2(max2(REG_SLOT_C, REG_REC_C),
                                              max2(OD_SLOT_C, OD_REC_C));
    localparam int unsigned CW         = $clog2(MAX_C + 1);
    localparam int unsigned LOW_MAX_C  = max2(REG_LOW0_C, OD_LOW0_C);

    sws_req_t      req_info, cur;
    logic [CW-1:0] low_len, slot_len, rec_len, smp_pt;

    assign req_info.rd   = slot_rd;
    assign req_info.wbit = wr_bit;
    assign req_info.od   = speed_od;

    sws_speed_table #(
        .CW         (CW),
        .REG_LOW1_C (REG_LOW1_C),
        .REG_LOW0_C (REG_LOW0_C),
        .REG_SLOT_C (REG_SLOT_C),
        .REG_REC_C  (REG_REC_C),
        .REG_SMP_C  (REG_SMP_C),
        .OD_LOW1_C  (OD_LOW1_C),
        .OD_LOW0_C  (OD_LOW0_C),
        .OD_SLOT_C  (OD_SLOT_C),
        .OD_REC_C   (OD_REC_C),
        .OD_SMP_C   (OD_SMP_C)
    ) u_table (
        .cur      (cur),
        .low_len  (low_len),
        .slot_len (slot_len),
        .rec_len  (rec_len),
        .smp_pt   (smp_pt)
    );

    sws_slot_fsm #(
        .CW (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_info (req_info),
        .line_in  (line_in),
        .low_len  (low_len),
        .slot_len (slot_len),
        .rec_len  (rec_len),
        .smp_pt   (smp_pt),
        .cur      (cur),
        .ready    (ready),
        .pull_low (pull_low),
        .done     (done),
        .rd_bit   (rd_bit)
    );

endmodule

// File: rtl/sws_slot_checker.sv
module sws_slot_checker #(
    parameter int unsigned LOW_MAX = 640
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic ready,
    input logic pull_low,
    input logic done
);

    // Length of the current low run on the line drive
    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (!rst_n)        low_run <= 0;
        else if (pull_low) low_run <= low_run + 1;
        else               low_run <= 0;
    end

    // R5: an accepted request starts a slot in the next cycle
    assert_accept_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> (pull_low && !ready));

    // R5: no drive while ready is offered
    assert_busy_while_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |-> !ready);

    // R9: completion strobe lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: strobe coincides with ready and a released line
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ready && !pull_low));

    // R3: no low pulse exceeds the long-pulse width
    assert_low_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= LOW_MAX);

    // R7: while busy the line drive can only begin from an idle cycle
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !pull_low) |=> !$rose(pull_low));

endmodule

bind sws_slot_master sws_slot_checker #(.LOW_MAX(LOW_MAX_C)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .ready    (ready),
    .pull_low (pull_low),
    .done     (done)
);

// File: tb/tb_sws_slot_master.sv
module tb_sws_slot_master;

    localparam int CLK_PERIOD = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, slot_rd = 1'b0, wr_bit = 1'b0, speed_od = 1'b0;
    logic ready, pull_low, done, rd_bit, line_in;
    logic slave_low = 1'b0;
    bit   slave_zero = 1'b0, slave_od = 1'b0;

    int checks = 0;
    int fails = 0;
    int issued = 0;
    int seen = 0;

    typedef struct {
        bit rd; bit bv; bit od; bit poke;
        int low; int tot; bit rbit;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Open-drain line with pull-up: low if master or slave pulls
    assign line_in = ~(pull_low | slave_low);

    sws_slot_master dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .slot_rd  (slot_rd),
        .wr_bit   (wr_bit),
        .speed_od (speed_od),
        .ready    (ready),
        .pull_low (pull_low),
        .line_in  (line_in),
        .done     (done),
        .rd_bit   (rd_bit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: issue one slot and queue what it should produce
    task automatic run_slot(input bit rd, input bit bv, input bit od,
                            input bit zero_slave, input bit poke);
        exp_t e;
        while (!ready) @(negedge clk);
        e.rd = rd; e.bv = bv; e.od = od; e.poke = poke;
        e.low  = (rd || bv) ? (od ? 10 : 60) : (od ? 75 : 640);
        e.tot  = od ? 125 : 750;
        e.rbit = (rd || bv) ? !zero_slave : 1'b0;
        q.push_back(e);
        issued++;
        slave_zero = zero_slave;
        slave_od   = od;
        req = 1'b1; slot_rd = rd; wr_bit = bv; speed_od = od;
        @(negedge clk);
        req = 1'b0;
        if (poke) begin
            // R7/R8: flip every input and request again while busy
            repeat (3) @(negedge clk);
            req = 1'b1; slot_rd = !rd; wr_bit = !bv; speed_od = !od;
            repeat (20) @(negedge clk);
            req = 1'b0;
        end
    endtask

    // Slave model: optionally holds the line low after the master's falling edge
    initial begin
        forever begin
            @(posedge pull_low);
            if (slave_zero) begin
                slave_low = 1'b1;
                repeat (slave_od ? 40 : 300) @(negedge clk);
                slave_low = 1'b0;
            end
        end
    end

    // Monitor: measure each slot and compare with the queued expectation
    initial begin
        exp_t e;
        int lw, tot;
        bit ready_bad;
        string tl;
        @(posedge rst_n);
        @(negedge clk);
        forever begin
            while (!pull_low) @(negedge clk);
            seen++;
            if (q.size() == 0) begin
                chk(1'b0, "R7 spurious slot", 1, 0);
                e.rd = 0; e.bv = 0; e.od = 0; e.poke = 0; e.low = 0; e.tot = 0; e.rbit = 0;
            end else begin
                e = q.pop_front();
            end
            lw = 0; tot = 0; ready_bad = 0;
            while (pull_low) begin
                if (ready) ready_bad = 1;
                lw++;
                @(negedge clk);
                tot++;
            end
            while (!done) begin
                if (ready) ready_bad = 1;
                @(negedge clk);
                tot++;
            end
            tl = e.rd ? "R4 read low width" : (e.bv ? "R2 write-one low width" : "R3 write-zero low width");
            if (e.poke) tl = {tl, " R8"};
            chk(lw == e.low, tl, lw, e.low);
            chk(tot == e.tot, e.poke ? "R5 R8 slot+recovery length" : "R5 slot+recovery length", tot, e.tot);
            chk(!ready_bad, "R5 ready low while busy", ready_bad, 0);
            chk(ready == 1'b1 && pull_low == 1'b0, "R9 ready high and line free at done",
                {ready, pull_low}, 2);
            chk(rd_bit == e.rbit, e.rd ? "R4 read bit" : "R6 write sampled bit", rd_bit, e.rbit);
            @(negedge clk);
            chk(done == 1'b0, "R9 done single cycle", done, 0);
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ready == 1'b1,    "R1 ready after reset",    ready, 1);
        chk(pull_low == 1'b0, "R1 pull_low after reset", pull_low, 0);
        chk(done == 1'b0,     "R1 done after reset",     done, 0);
        chk(rd_bit == 1'b0,   "R1 rd_bit after reset",   rd_bit, 0);

        // R2/R6: write-one, regular and overdrive
        run_slot(0, 1, 0, 0, 0);
        run_slot(0, 1, 1, 0, 0);
        // R3/R6: write-zero, both speeds
        run_slot(0, 0, 0, 0, 0);
        run_slot(0, 0, 1, 0, 0);
        // R4: reads, free line and slave holding low, both speeds
        run_slot(1, 0, 0, 0, 0);
        run_slot(1, 0, 0, 1, 0);
        run_slot(1, 1, 1, 0, 0);
        run_slot(1, 0, 1, 1, 0);
        // R6: write-one with the slave pulling low samples zero
        run_slot(0, 1, 0, 1, 0);
        run_slot(0, 1, 1, 1, 0);
        // R7/R8: mid-slot request and input changes are ignored
        run_slot(0, 1, 0, 0, 1);
        run_slot(0, 0, 1, 0, 1);
        run_slot(1, 0, 0, 1, 1);
        // Back-to-back mixed speeds
        run_slot(0, 0, 0, 0, 0);
        run_slot(1, 1, 1, 0, 0);
        run_slot(0, 1, 0, 0, 0);

        while (!(ready && q.size() == 0 && !done)) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(seen == issued, "R7 slot count matches accepted requests", seen, issued);
        chk(pull_low == 1'b0 && ready == 1'b1, "R7 idle after ignored requests",
            {pull_low, ready}, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule